// File: doc/BRIEF.md
# Bidirectional-Pin Universal Shift Register

This block is a WIDTH-bit storage register (8 by default) with four operations chosen by a 2-bit mode input: keep the current value, move every bit one place toward the most significant end, move every bit one place toward the least significant end, or capture a full word at once. Every change of state happens on the rising clock edge. An active-low master reset clears the whole word at any moment. It takes priority over the clock and the mode.

The parallel data path in and out shares one set of package pins. The block does not use tristate nets. It gives the pin side as three signals: a pin-input vector that carries the resolved bus value, a pin-output vector that always equals the register contents, and a single drive enable. The pins are driven only when both active-low enables are low and the block is not capturing a word. This keeps the block off the bus while external logic supplies the data. Each shift direction has its own serial input. The least and most significant bits each appear on a dedicated serial output at all times, so that several registers can be chained into a wider shifter.

Top module: `univ_shifter`

## Requirements
- R1: A low level on `rstN` clears every bit of `pinOut` at once, without waiting for a clock edge. While it stays low, the register stays zero whatever the clock, the mode or the data inputs.
- R2: With `modeSel` = 2'b00 (hold), a rising clock edge leaves the register contents unchanged.
- R3: With `modeSel` = 2'b01 (shift toward the MSB), a rising edge loads bit 0 from `serInLow`, and each bit n takes the old value of bit n-1.
- R4: With `modeSel` = 2'b10 (shift toward the LSB), a rising edge loads the top bit from `serInHigh`, and each bit n takes the old value of bit n+1.
- R5: With `modeSel` = 2'b11 (parallel capture), a rising edge loads each bit n from `pinIn[n]`.
- R6: `pinOut` always equals the register contents, whatever the state of the enables.
- R7: `pinOe` is 1 only when `oeAN` and `oeBN` are both 0 and `modeSel` is not 2'b11. Otherwise it is 0.
- R8: `serOutLow` always equals register bit 0 and `serOutHigh` always equals the top bit, whatever the state of the enables.
- R9: Between rising clock edges, changes on `modeSel`, `serInLow`, `serInHigh` or `pinIn` do not alter the register contents.
- R10: When two instances are chained (the upper half's `serInLow` is driven from the lower half's `serOutHigh`, and the lower half's `serInHigh` is driven from the upper half's `serOutLow`) and both run the same shift mode, they behave as one shifter of twice the width, in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rstN | input | 1 | Asynchronous master reset, active low |
| modeSel | input | 2 | Operation: 00 hold, 01 shift toward MSB, 10 shift toward LSB, 11 parallel capture |
| serInLow | input | 1 | Serial data that enters bit 0 when shifting toward the MSB |
| serInHigh | input | 1 | Serial data that enters the top bit when shifting toward the LSB |
| oeAN | input | 1 | First pin output enable, active low |
| oeBN | input | 1 | Second pin output enable, active low |
| pinIn | input | WIDTH | Resolved value on the shared pins, used as parallel capture data |
| pinOut | output | WIDTH | Register contents offered to the pin drivers |
| pinOe | output | 1 | Drive enable for the shared pins |
| serOutLow | output | 1 | Register bit 0, always visible |
| serOutHigh | output | 1 | Register top bit, always visible |

## Verification
The bench uses the default WIDTH of 8 for the instance under test. It resolves the shared bus itself: the block's pinOut is selected when pinOe is high, and an external driver is selected otherwise. It also builds two more 8-bit instances, chained through their serial pins. This gives a 16-bit shifter, so the bench can follow a bit as it crosses from one instance into the other in each direction and compare the result against a 16-bit model. Reset is asserted halfway through a clock period while a capture is pending. This shows that the clear acts at once and that it overrides the capture.

// File: rtl/univ_shifter_pkg.sv
package univ_shifter_pkg;

  // Encoding of the operation select, high bit first.
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_UP    = 2'b01,  // bits move toward the MSB, serInLow enters bit 0
    MODE_DOWN  = 2'b10,  // bits move toward the LSB, serInHigh enters the top bit
    MODE_LOAD  = 2'b11   // capture the shared pins
  } modeT;

  // Strobes from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic loadEn;
    logic upEn;
    logic downEn;
  } strobeT;

endpackage

// File: rtl/univ_shifter_ctrl.sv
module univ_shifter_ctrl
  import univ_shifter_pkg::*;
(
  input  logic [1:0] modeSel,
  input  logic       oeAN,
  input  logic       oeBN,
  output strobeT     strobes,
  output logic       driveEn
);

  modeT mode;
  logic bothEnabled;

  assign mode        = modeT'(modeSel);
  assign bothEnabled = ~(oeAN | oeBN);

  always_comb begin
    strobes = '0;
    unique case (mode)
      MODE_LOAD: strobes.loadEn = 1'b1;
      MODE_UP:   strobes.upEn   = 1'b1;
      MODE_DOWN: strobes.downEn = 1'b1;
      default:   strobes        = '0;
    endcase
  end

  // The block does not drive the pins while it captures from them.
  assign driveEn = bothEnabled & ~strobes.loadEn;

endmodule

// File: rtl/univ_shifter_datapath.sv
module univ_shifter_datapath
  import univ_shifter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobes,
  input  logic             serInLow,
  input  logic             serInHigh,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] regQ
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nextQ;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic fromBelow;
    logic fromAbove;

    if (i == 0) begin : g_low_end
      assign fromBelow = serInLow;
    end else begin : g_low_mid
      assign fromBelow = regQ[i-1];
    end

    if (i == TOP) begin : g_high_end
      assign fromAbove = serInHigh;
    end else begin : g_high_mid
      assign fromAbove = regQ[i+1];
    end

    always_comb begin
      if (strobes.loadEn)      nextQ[i] = pinIn[i];
      else if (strobes.upEn)   nextQ[i] = fromBelow;
      else if (strobes.downEn) nextQ[i] = fromAbove;
      else                     nextQ[i] = regQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= '0;
    else       regQ <= nextQ;
  end

endmodule

// File: rtl/univ_shifter.sv
module univ_shifter
  import univ_shifter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             serInLow,
  input  logic             serInHigh,
  input  logic             oeAN,
  input  logic             oeBN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic             pinOe,
  output logic             serOutLow,
  output logic             serOutHigh
);

  strobeT           strobes;
  logic [WIDTH-1:0] regQ;

  univ_shifter_ctrl uCtrl (
    .modeSel (modeSel),
    .oeAN    (oeAN),
    .oeBN    (oeBN),
    .strobes (strobes),
    .driveEn (pinOe)
  );

  univ_shifter_datapath #(.WIDTH(WIDTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .serInLow  (serInLow),
    .serInHigh (serInHigh),
    .pinIn     (pinIn),
    .regQ      (regQ)
  );

  assign pinOut     = regQ;
  assign serOutLow  = regQ[0];
  assign serOutHigh = regQ[WIDTH-1];

endmodule

// File: rtl/univ_shifter_checker.sv
module univ_shifter_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       modeSel,
  input logic             serInLow,
  input logic             serInHigh,
  input logic             oeAN,
  input logic             oeBN,
  input logic [WIDTH-1:0] pinIn,
  input logic [WIDTH-1:0] pinOut,
  input logic             pinOe,
  input logic             serOutLow,
  input logic             serOutHigh
);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinOut == '0)); // R1

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00) |=> $stable(pinOut)); // R2

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b01) |=> (pinOut == {$past(pinOut[WIDTH-2:0]), $past(serInLow)})); // R3

  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b10) |=> (pinOut == {$past(serInHigh), $past(pinOut[WIDTH-1:1])})); // R4

  AST_LOAD_PINS: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b11) |=> (pinOut == $past(pinIn))); // R5

  AST_DRIVE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    pinOe |-> (!oeAN && !oeBN)); // R7

  AST_NO_DRIVE_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b11) |-> !pinOe); // R7

  AST_SERIAL_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (serOutLow == pinOut[0]) && (serOutHigh == pinOut[WIDTH-1])); // R8

endmodule

bind univ_shifter univ_shifter_checker #(.WIDTH(WIDTH)) uChk (.*);

// File: tb/univ_shifter_bench.sv
module univ_shifter_bench;

  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rstN = 1'b0;
  logic [1:0]   modeSel = 2'b00;
  logic         serInLow = 1'b0, serInHigh = 1'b0;
  logic         oeAN = 1'b1, oeBN = 1'b1;
  logic [W-1:0] extDrive = '0;
  logic [W-1:0] busVal, pinOut;
  logic         pinOe, serOutLow, serOutHigh;

  // Bus resolution: the block wins when it drives, else the external source.
  assign busVal = pinOe ? pinOut : extDrive;

  univ_shifter #(.WIDTH(W)) u_univ_shifter (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .serInLow(serInLow),
    .serInHigh(serInHigh), .oeAN(oeAN), .oeBN(oeBN), .pinIn(busVal),
    .pinOut(pinOut), .pinOe(pinOe), .serOutLow(serOutLow), .serOutHigh(serOutHigh)
  );

  // Chained pair for the double-width checks.
  logic [1:0]   cMode = 2'b00;
  logic         cInLow = 1'b0, cInHigh = 1'b0;
  logic [W-1:0] cExtLo = '0, cExtHi = '0;
  logic [W-1:0] cOutLo, cOutHi;
  logic         cOeLo, cOeHi, loSoL, loSoH, hiSoL, hiSoH;

  univ_shifter #(.WIDTH(W)) uCascLo (
    .clk(clk), .rstN(rstN), .modeSel(cMode), .serInLow(cInLow),
    .serInHigh(hiSoL), .oeAN(1'b1), .oeBN(1'b1), .pinIn(cExtLo),
    .pinOut(cOutLo), .pinOe(cOeLo), .serOutLow(loSoL), .serOutHigh(loSoH)
  );

  univ_shifter #(.WIDTH(W)) uCascHi (
    .clk(clk), .rstN(rstN), .modeSel(cMode), .serInLow(loSoH),
    .serInHigh(cInHigh), .oeAN(1'b1), .oeBN(1'b1), .pinIn(cExtHi),
    .pinOut(cOutHi), .pinOe(cOeHi), .serOutLow(hiSoL), .serOutHigh(hiSoH)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard
  typedef struct {
    logic [W-1:0] q;
    string        req;
  } expT;
  expT expQ[$];
  logic [W-1:0] refQ = '0;

  // Driver: sets inputs at the falling edge and queues the value due after the next rising edge.
  task automatic step(input logic [1:0] m, input logic sl, input logic sh,
                      input logic [W-1:0] ext, input string req);
    expT e;
    @(negedge clk);
    modeSel = m; serInLow = sl; serInHigh = sh; extDrive = ext;
    case (m)
      2'b01:   refQ = {refQ[W-2:0], sl};
      2'b10:   refQ = {sh, refQ[W-1:1]};
      2'b11:   refQ = ext;
      default: refQ = refQ;
    endcase
    e.q = refQ; e.req = req;
    expQ.push_back(e);
  endtask

  // Monitor: compares one queued item after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expT e;
        e = expQ.pop_front();
        chk(pinOut === e.q, e.req, {8'h00, pinOut}, {8'h00, e.q});
        chk(serOutLow === e.q[0] && serOutHigh === e.q[W-1], "R8 serial ends",
            {14'h0, serOutHigh, serOutLow}, {14'h0, e.q[W-1], e.q[0]});
      end
    end
  end

  task automatic oeCheck(input logic a, input logic b, input logic [1:0] m, input logic exp);
    @(negedge clk);
    oeAN = a; oeBN = b; modeSel = m; extDrive = refQ;
    #1;
    chk(pinOe === exp, "R7 drive enable", {15'h0, pinOe}, {15'h0, exp});
    chk(pinOut === refQ, "R6 pinOut follows contents", {8'h0, pinOut}, {8'h0, refQ});
  endtask

  logic [15:0] casRef = '0;

  task automatic casStep(input logic [1:0] m, input logic sl, input logic sh);
    @(negedge clk);
    cMode = m; cInLow = sl; cInHigh = sh;
    case (m)
      2'b01:   casRef = {casRef[14:0], sl};
      2'b10:   casRef = {sh, casRef[15:1]};
      2'b11:   casRef = {cExtHi, cExtLo};
      default: casRef = casRef;
    endcase
    @(posedge clk);
    #1;
    chk({cOutHi, cOutLo} === casRef, "R10 chained shift", {cOutHi, cOutLo}, casRef);
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Reset state
    #5;
    chk(pinOut === '0, "R1 reset value", {8'h0, pinOut}, 16'h0);
    chk(pinOe === 1'b0, "R7 idle enables", {15'h0, pinOe}, 16'h0);
    @(negedge clk);
    rstN = 1'b1;

    // Parallel capture from the external source (block not driving)
    step(2'b11, 1'b0, 1'b0, 8'hA5, "R5 capture A5");
    step(2'b00, 1'b1, 1'b1, 8'hFF, "R2 hold");
    step(2'b00, 1'b0, 1'b1, 8'h00, "R2 hold again");
    // Shifts toward MSB
    step(2'b01, 1'b1, 1'b0, 8'h00, "R3 up in 1");
    step(2'b01, 1'b0, 1'b1, 8'h00, "R3 up in 0");
    step(2'b01, 1'b1, 1'b1, 8'h00, "R3 up in 1");
    // Shifts toward LSB
    step(2'b11, 1'b0, 1'b0, 8'h3C, "R5 capture 3C");
    step(2'b10, 1'b0, 1'b1, 8'h00, "R4 down in 1");
    step(2'b10, 1'b1, 1'b0, 8'h00, "R4 down in 0");
    step(2'b10, 1'b0, 1'b1, 8'h00, "R4 down in 1");
    step(2'b11, 1'b0, 1'b0, 8'h81, "R5 capture 81");
    for (int k = 0; k < W; k++) step(2'b10, 1'b0, 1'b0, 8'h00, "R4 drain down");
    step(2'b00, 1'b0, 1'b0, 8'h00, "R2 hold zero");
    @(posedge clk); #1;

    // Drive enable combinations (register kept unchanged)
    oeCheck(1'b0, 1'b0, 2'b00, 1'b1);
    oeCheck(1'b1, 1'b0, 2'b00, 1'b0);
    oeCheck(1'b0, 1'b1, 2'b01, 1'b0);
    oeCheck(1'b0, 1'b0, 2'b11, 1'b0);
    @(negedge clk);
    modeSel = 2'b00; oeAN = 1'b1; oeBN = 1'b1;

    // Enabled outputs do not change what a step does; serial ends stay visible
    @(negedge clk);
    oeAN = 1'b0; oeBN = 1'b0;
    step(2'b01, 1'b1, 1'b0, 8'h00, "R3 up while driving");
    step(2'b11, 1'b0, 1'b0, 8'h5A, "R5 capture with enables low");
    step(2'b00, 1'b0, 1'b0, 8'h00, "R2 hold while driving");
    @(posedge clk); #1;
    chk(pinOe === 1'b1, "R7 driving after capture", {15'h0, pinOe}, 16'h1);
    chk(busVal === 8'h5A, "R6 bus carries contents", {8'h0, busVal}, 16'h005A);

    // Mid-cycle input changes have no effect before the edge
    @(posedge clk); #1;
    serInLow = 1'b1; serInHigh = 1'b1; extDrive = 8'hC3;
    #1;
    chk(pinOut === refQ, "R9 no change between edges", {8'h0, pinOut}, {8'h0, refQ});
    modeSel = 2'b00;

    // Reset in the middle of a cycle while a capture is pending
    @(negedge clk);
    modeSel = 2'b11; oeAN = 1'b1; oeBN = 1'b1; extDrive = 8'hEE;
    rstN = 1'b0;
    #1;
    chk(pinOut === '0, "R1 asynchronous clear", {8'h0, pinOut}, 16'h0);
    @(posedge clk); #1;
    chk(pinOut === '0, "R1 overrides capture", {8'h0, pinOut}, 16'h0);
    chk(serOutLow === 1'b0 && serOutHigh === 1'b0, "R8 ends after clear",
        {14'h0, serOutHigh, serOutLow}, 16'h0);
    @(negedge clk);
    modeSel = 2'b00; rstN = 1'b1; refQ = '0;

    // Chained double-width shifter
    cExtLo = 8'hC3; cExtHi = 8'hA5;
    casStep(2'b11, 1'b0, 1'b0);
    casStep(2'b01, 1'b1, 1'b0);
    casStep(2'b01, 1'b0, 1'b0);
    casStep(2'b01, 1'b1, 1'b1);
    casStep(2'b10, 1'b0, 1'b1);
    casStep(2'b10, 1'b1, 1'b0);
    for (int k = 0; k < 10; k++) casStep(2'b10, k[0], 1'b1);
    for (int k = 0; k < 9; k++) casStep(2'b01, ~k[0], 1'b0);
    casStep(2'b00, 1'b1, 1'b1);

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule